// File: doc/BRIEF.md
# Serial Command Port for a Power-Management Control Register

This block is a serial slave port that lets a host controller drive a 16-bit control register and read back an 8-bit diagnostic word. It sits between a four-wire serial bus (select, clock, data in, data out) and the on-chip logic that enables regulators and drivers. All bus pins are brought into the system clock domain through synchronisers, and the port acts on the clock edges it detects there. The serial clock must therefore run several times slower than the system clock.

Each frame starts with a one-byte opcode, sent most-significant bit first. The opcode either arms or disarms a write-enable latch, writes the control register, or starts a read of the control or diagnostic word. Every control write must be armed beforehand by a separate frame, and the latch disarms again once a write is applied. A write is committed only when select rises after a complete data word. Unknown opcodes do nothing.

Finishing a read of the diagnostic word raises a one-cycle pulse and clears the diagnostic-start control bit. The data output floats whenever the port is deselected.

Top module: `spi_cmd_port`

## Requirements
- R1: The port works with the clock idling low or high: data in is sampled on the rising serial clock edge, and data out changes only after a falling edge.
- R2: Opcode and data bits travel most-significant bit first. The first rising clock edge after select falls carries the opcode MSB.
- R3: Opcode 0x06 arms the write-enable latch and opcode 0x04 disarms it. Reset also disarms it.
- R4: Opcode 0x02 followed by 16 data bits loads the control register, but only if the latch was armed before the frame. An applied write disarms the latch. Without an armed latch the register is unchanged.
- R5: A write frame that ends (select rises) before all 16 data bits have arrived changes nothing.
- R6: Opcode 0x03 returns the 16-bit control register MSB first. The first bit is driven after the falling edge that follows the opcode LSB.
- R7: Opcode 0x05 returns the 8-bit diag_in word MSB first. When select rises after all 8 bits have been clocked, diag_rd_done pulses for one cycle and control bit 0 (diagnostic start) is cleared. A shorter read does neither.
- R8: An opcode outside {0x02, 0x03, 0x04, 0x05, 0x06} affects neither the latch nor the control register, and the data output stays floating.
- R9: After opcode 0x06 or 0x04 is executed, further clocks in the same frame are ignored until select rises.
- R10: spi_miso floats whenever spi_cs_n is high, and also outside the data phase of a read.
- R11: While rst_n is low, the control register and latch clear and the port returns to the deselected state.
- R12: Only control bits 15, 14, 13, 10, 9, 1 and 0 are writable; the others read 0. A write with bit 1 (test mode) set stores bits 15..2 as 0.
- R13: Clock edges after the 16th write data bit are ignored; the first 16 bits are committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the port |
| spi_miso | output | 1 | Serial data out of the port; floats when not driving |
| diag_in | input | DIAG_W (8) | Diagnostic word presented by the fault logic |
| ctrl_bits | output | CTRL_W (16) | Control register contents |
| diag_rd_done | output | 1 | One-cycle pulse after a complete diagnostic read |

## Verification
The bench uses the default parameters: two synchroniser stages, a 16-bit control word, an 8-bit diagnostic word, and writable mask 0xE603. With these values, data-out changes about four system clocks after each falling serial edge, so a serial half period of six system clocks exposes both the read alignment and the late-commit window. The bench also runs frames in both clock polarities, with partial, over-long and chained-opcode frames, so that every commit and discard path of the 16-bit write is reached.

// File: rtl/spi_cmd_pkg.sv
// Shared opcodes and state encodings for the serial command port.
// Assumes 8-bit opcodes sent most-significant bit first.
package spi_cmd_pkg;

    localparam int OPC_W = 8;

    typedef enum logic [7:0] {
        OPC_ARM     = 8'h06,
        OPC_DISARM  = 8'h04,
        OPC_WR_CTRL = 8'h02,
        OPC_RD_DIAG = 8'h05,
        OPC_RD_CTRL = 8'h03
    } opcode_e;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_OPCODE,
        PS_WDATA,
        PS_RDATA,
        PS_PARK
    } port_state_e;

    typedef enum logic {
        SRC_CTRL,
        SRC_DIAG
    } rd_src_e;

endpackage

// File: rtl/spi_pin_sync.sv
// Multi-stage synchroniser for one asynchronous input bit.
// Assumes STAGES >= 1; the reset value sets the idle level seen after reset.
module spi_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the pin level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= (chain << 1) | STAGES'(d);
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_front.sv
// Pin front end: synchronises select, clock and data in, and derives
// edge strobes in the system clock domain.
// Assumes the serial clock is well below half the system clock rate.
module spi_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sck_pin,
    input  logic mosi_pin,
    output logic cs_n_s,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    logic sck_s;
    logic sck_d;
    logic cs_d;

    spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs (
        .clk(clk), .rst_n(rst_n), .d(cs_n_pin), .q(cs_n_s));
    spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck (
        .clk(clk), .rst_n(rst_n), .d(sck_pin), .q(sck_s));
    spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mosi (
        .clk(clk), .rst_n(rst_n), .d(mosi_pin), .q(mosi_s));

    // Keep the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign cs_rise  = cs_n_s & ~cs_d;
endmodule

// File: rtl/spi_cmd_ctrl.sv
// Frame decoder and register file: decodes opcodes, collects write data,
// guards writes with the arm latch and prepares read words for shifting.
// Assumes edge strobes from spi_front; writes and read side effects commit
// on the select rising strobe.
module spi_cmd_ctrl
    import spi_cmd_pkg::*;
#(
    parameter int                CTRL_W     = 16,
    parameter int                DIAG_W     = 8,
    parameter logic [CTRL_W-1:0] CTRL_WMASK = 16'hE603,
    parameter int                TEST_BIT   = 1,
    parameter int                START_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              cs_rise,
    input  logic              sck_rise,
    input  logic              mosi_s,
    input  logic [DIAG_W-1:0] diag_in,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              rd_active,
    output logic              tx_load,
    output logic [CTRL_W-1:0] tx_word,
    output logic              diag_rd_pulse
);
    localparam int                CNT_W        = $clog2(CTRL_W + OPC_W);
    localparam logic [CTRL_W-1:0] KEEP_IN_TEST = (CTRL_W'(1) << TEST_BIT) |
                                                 (CTRL_W'(1) << START_BIT);

    port_state_e       state;
    rd_src_e           rd_src;
    logic [CNT_W-1:0]  cnt;
    logic [CTRL_W-1:0] shreg;
    logic              wr_full;
    logic              rd_done;
    logic              wel_q;

    logic              opc_done;
    logic [OPC_W-1:0]  opc_now;
    logic              commit_wr;
    logic              commit_rd;
    logic [CNT_W-1:0]  rd_last;

    // Apply the writable mask and the test-mode forcing to a write word.
    function automatic logic [CTRL_W-1:0] shape_word(input logic [CTRL_W-1:0] w);
        logic [CTRL_W-1:0] m;
        m = w & CTRL_WMASK;
        if (m[TEST_BIT]) m = m & KEEP_IN_TEST;
        return m;
    endfunction

    // Decode strobes shared by the frame and register processes.
    always_comb begin
        opc_now   = {shreg[OPC_W-2:0], mosi_s};
        opc_done  = (state == PS_OPCODE) && sck_rise && (cnt == CNT_W'(OPC_W-1));
        commit_wr = cs_rise && (state == PS_WDATA) && wr_full && wel_q;
        commit_rd = cs_rise && (state == PS_RDATA) && (rd_src == SRC_DIAG) && rd_done;
        rd_last   = (rd_src == SRC_DIAG) ? CNT_W'(DIAG_W-1) : CNT_W'(CTRL_W-1);
    end

    assign rd_active = (state == PS_RDATA);

    // Frame sequencing: state, bit counter and input shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PS_IDLE;
            rd_src  <= SRC_CTRL;
            cnt     <= '0;
            shreg   <= '0;
            wr_full <= 1'b0;
            rd_done <= 1'b0;
        end else if (cs_n_s) begin
            state <= PS_IDLE;
        end else begin
            case (state)
                PS_IDLE: begin
                    state   <= PS_OPCODE;
                    cnt     <= '0;
                    wr_full <= 1'b0;
                    rd_done <= 1'b0;
                end
                PS_OPCODE: begin
                    if (sck_rise) begin
                        shreg <= {shreg[CTRL_W-2:0], mosi_s};
                        cnt   <= cnt + 1'b1;
                    end
                    if (opc_done) begin
                        cnt <= '0;
                        case (opc_now)
                            OPC_WR_CTRL: state <= PS_WDATA;
                            OPC_RD_CTRL: begin
                                state  <= PS_RDATA;
                                rd_src <= SRC_CTRL;
                            end
                            OPC_RD_DIAG: begin
                                state  <= PS_RDATA;
                                rd_src <= SRC_DIAG;
                            end
                            default:     state <= PS_PARK;
                        endcase
                    end
                end
                PS_WDATA: begin
                    if (sck_rise && !wr_full) begin
                        shreg <= {shreg[CTRL_W-2:0], mosi_s};
                        cnt   <= cnt + 1'b1;
                        if (cnt == CNT_W'(CTRL_W-1)) wr_full <= 1'b1;
                    end
                end
                PS_RDATA: begin
                    if (sck_rise && !rd_done) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == rd_last) rd_done <= 1'b1;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    // Register file: arm latch, control word, read word and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q         <= 1'b0;
            ctrl_q        <= '0;
            tx_load       <= 1'b0;
            tx_word       <= '0;
            diag_rd_pulse <= 1'b0;
        end else begin
            tx_load       <= 1'b0;
            diag_rd_pulse <= 1'b0;
            if (commit_wr) begin
                ctrl_q <= shape_word(shreg);
                wel_q  <= 1'b0;
            end
            if (commit_rd) begin
                ctrl_q[START_BIT] <= 1'b0;
                diag_rd_pulse     <= 1'b1;
            end
            if (opc_done) begin
                case (opc_now)
                    OPC_ARM:     wel_q <= 1'b1;
                    OPC_DISARM:  wel_q <= 1'b0;
                    OPC_RD_CTRL: begin
                        tx_word <= ctrl_q;
                        tx_load <= 1'b1;
                    end
                    OPC_RD_DIAG: begin
                        tx_word <= CTRL_W'(diag_in) << (CTRL_W - DIAG_W);
                        tx_load <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_WRITE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q[CTRL_W-1:1]) |-> $past(wel_q)); // R4
    AST_ARM_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q[CTRL_W-1:1]) |-> !wel_q); // R4
    AST_TEST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[TEST_BIT] |-> ((ctrl_q & ~KEEP_IN_TEST) == '0)); // R12
    AST_PARK_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_PARK) && !cs_n_s |=> $stable(wel_q) && $stable(ctrl_q)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        diag_rd_pulse |=> !diag_rd_pulse); // R7
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !rd_active); // R10
endmodule

// File: rtl/spi_tx_shift.sv
// Output shifter: holds a read word and presents one bit per falling
// serial edge, MSB first.
// Assumes load arrives before the first falling edge of the data phase.
module spi_tx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         shift_en,
    output logic         bit_q
);
    logic [W-1:0] sr;

    // Load a fresh word or advance by one bit on each falling strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr    <= '0;
            bit_q <= 1'b0;
        end else if (load) begin
            sr    <= word;
            bit_q <= 1'b0;
        end else if (shift_en) begin
            bit_q <= sr[W-1];
            sr    <= sr << 1;
        end
    end
endmodule

// File: rtl/spi_cmd_port.sv
// Top of the serial command port: pin front end, frame decoder and register
// file, output shifter and tri-state data out.
// Assumes a serial half period of several system clocks.
module spi_cmd_port #(
    parameter int                SYNC_STAGES = 2,
    parameter int                CTRL_W      = 16,
    parameter int                DIAG_W      = 8,
    parameter logic [CTRL_W-1:0] CTRL_WMASK  = 16'hE603
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [DIAG_W-1:0] diag_in,
    output logic [CTRL_W-1:0] ctrl_bits,
    output logic              diag_rd_done
);
    logic              cs_n_s;
    logic              cs_rise;
    logic              sck_rise;
    logic              sck_fall;
    logic              mosi_s;
    logic              rd_active;
    logic              tx_load;
    logic [CTRL_W-1:0] tx_word;
    logic              tx_bit;

    spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n),
        .cs_n_pin(spi_cs_n), .sck_pin(spi_sck), .mosi_pin(spi_mosi),
        .cs_n_s(cs_n_s), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s));

    spi_cmd_ctrl #(.CTRL_W(CTRL_W), .DIAG_W(DIAG_W), .CTRL_WMASK(CTRL_WMASK)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(cs_n_s), .cs_rise(cs_rise), .sck_rise(sck_rise), .mosi_s(mosi_s),
        .diag_in(diag_in), .ctrl_q(ctrl_bits), .rd_active(rd_active),
        .tx_load(tx_load), .tx_word(tx_word), .diag_rd_pulse(diag_rd_done));

    spi_tx_shift #(.W(CTRL_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .word(tx_word),
        .shift_en(sck_fall && rd_active), .bit_q(tx_bit));

    // Drive data out only in a read data phase while the raw select is low.
    assign spi_miso = (rd_active && !spi_cs_n) ? tx_bit : 1'bz;
endmodule

// File: tb/tb_spi_cmd_port.sv
module tb_spi_cmd_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 6;
    localparam int SETTLE     = 8;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        mosi = 1'b0;
    logic [7:0]  diag_val = 8'h00;
    wire  [15:0] ctrl_bits;
    wire         diag_rd_done;
    wire         miso_net;

    pullup (miso_net);

    spi_cmd_port dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso_net), .diag_in(diag_val), .ctrl_bits(ctrl_bits),
        .diag_rd_done(diag_rd_done));

    always #(CLK_PERIOD/2) clk = ~clk;

    int          vectors = 0;
    int          miscompares = 0;
    int          pulse_cnt = 0;
    logic [15:0] exp_ctrl = 16'h0000;
    bit          exp_wel = 1'b0;
    bit          settle = 1'b1;
    bit          done = 1'b0;
    string       cur_req = "R11";

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] model_write(input logic [15:0] w);
        logic [15:0] m;
        m = w & 16'hE603;
        if (m[1]) m = m & 16'h0003;
        return m;
    endfunction

    // Per-clock comparison against the reference state, away from the edge.
    always begin
        @(negedge clk);
        #1;
        if (diag_rd_done === 1'b1) pulse_cnt++;
        if (rst_n && !settle) begin
            check(cur_req, 32'(ctrl_bits), 32'(exp_ctrl), "ctrl per clock");
            check("R7", 32'(diag_rd_done), 32'd0, "no stray done pulse");
            if (cs_n) check("R10", 32'(miso_net), 32'd1, "miso floats while deselected");
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input bit mode3, input logic [39:0] bits_in,
                        input int nbits, output logic [39:0] got);
        got = '1;
        wait_clk(1);
        sck  = mode3;
        cs_n = 1'b0;
        wait_clk(HALF_SCK);
        for (int i = 0; i < nbits; i++) begin
            if (mode3) sck = 1'b0;
            mosi = bits_in[39-i];
            wait_clk(HALF_SCK);
            got[39-i] = miso_net;
            sck = 1'b1;
            wait_clk(HALF_SCK);
            if (!mode3) sck = 1'b0;
        end
        wait_clk(HALF_SCK);
        settle = 1'b1;
        cs_n   = 1'b1;
        wait_clk(SETTLE);
    endtask

    // One frame plus the reference model update and its checks.
    task automatic run(input string req, input bit mode3, input logic [7:0] opc,
                       input logic [31:0] data, input int nbits);
        logic [39:0] got;
        logic [15:0] old;
        int          ndata;
        int          exp_pulse;
        cur_req   = req;
        old       = exp_ctrl;
        ndata     = nbits - 8;
        exp_pulse = 0;
        pulse_cnt = 0;
        xfer(mode3, {opc, data}, nbits, got);
        for (int i = 0; i < 8 && i < nbits; i++)
            check("R10", 32'(got[39-i]), 32'd1, "miso floats in opcode phase");
        if (nbits >= 8) begin
            case (opc)
                8'h06: exp_wel = 1'b1;
                8'h04: exp_wel = 1'b0;
                8'h02: if (ndata >= 16 && exp_wel) begin
                    exp_ctrl = model_write(data[31:16]);
                    exp_wel  = 1'b0;
                end
                8'h03: for (int i = 0; i < ndata && i < 16; i++)
                    check(req, 32'(got[31-i]), 32'(old[15-i]), "control read bit");
                8'h05: begin
                    for (int i = 0; i < ndata && i < 8; i++)
                        check(req, 32'(got[31-i]), 32'(diag_val[7-i]), "diag read bit");
                    if (ndata >= 8) begin
                        exp_pulse   = 1;
                        exp_ctrl[0] = 1'b0;
                    end
                end
                default: ;
            endcase
            if (opc != 8'h03 && opc != 8'h05)
                for (int i = 0; i < ndata && i < 32; i++)
                    check("R10", 32'(got[31-i]), 32'd1, "miso floats outside read data");
        end
        check(req, 32'(pulse_cnt), 32'(exp_pulse), "done pulse count");
        check(req, 32'(ctrl_bits), 32'(exp_ctrl), "ctrl after frame");
        settle = 1'b0;
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        // R11: reset state
        check("R11", 32'(ctrl_bits), 32'd0, "ctrl after reset");
        check("R11", 32'(miso_net), 32'd1, "miso after reset");
        check("R11", 32'(diag_rd_done), 32'd0, "done after reset");
        settle = 1'b0;

        run("R4", 1'b0, 8'h02, {16'hE601, 16'h0}, 24);    // unarmed write rejected
        run("R3", 1'b0, 8'h06, 32'h0, 8);
        run("R4", 1'b0, 8'h02, {16'hE601, 16'h0}, 24);    // armed write, R2 MSB first
        run("R6", 1'b0, 8'h03, 32'h0, 24);
        run("R4", 1'b0, 8'h02, {16'h4400, 16'h0}, 24);    // latch dropped after write
        run("R1", 1'b1, 8'h06, 32'h0, 8);
        run("R1", 1'b1, 8'h02, {16'h5A58, 16'h0}, 24);    // R12 reserved bits read 0
        run("R1", 1'b1, 8'h03, 32'h0, 24);
        run("R2", 1'b0, 8'h03, 32'h0, 24);
        run("R3", 1'b0, 8'h06, 32'h0, 8);
        run("R3", 1'b0, 8'h04, 32'h0, 8);
        run("R3", 1'b0, 8'h02, {16'hE601, 16'h0}, 24);
        run("R9", 1'b0, 8'h06, {8'h04, 24'h0}, 16);        // trailing disarm byte ignored
        run("R9", 1'b0, 8'h02, {16'h8000, 16'h0}, 24);
        run("R3", 1'b0, 8'h06, 32'h0, 8);
        run("R8", 1'b0, 8'hA5, {16'hFFFF, 16'h0}, 24);
        run("R8", 1'b1, 8'h82, {16'hFFFF, 16'h0}, 24);
        run("R8", 1'b0, 8'h02, {16'h2000, 16'h0}, 24);    // latch survived invalid opcodes
        run("R3", 1'b0, 8'h06, 32'h0, 8);
        run("R5", 1'b0, 8'h02, {16'hC000, 16'h0}, 20);    // partial frame discarded
        run("R3", 1'b0, 8'h06, 32'h0, 8);
        run("R13", 1'b0, 8'h02, {16'h0600, 16'hFFFF}, 40);
        run("R3", 1'b1, 8'h06, 32'h0, 8);
        run("R12", 1'b1, 8'h02, {16'hE603, 16'h0}, 24);    // test mode forces 15..2 low
        diag_val = 8'hB6;
        run("R7", 1'b0, 8'h05, 32'h0, 16);
        run("R7", 1'b0, 8'h03, 32'h0, 24);
        run("R3", 1'b0, 8'h06, 32'h0, 8);
        run("R7", 1'b0, 8'h02, {16'h0601, 16'h0}, 24);
        diag_val = 8'h4D;
        run("R7", 1'b1, 8'h05, 32'h0, 12);                 // short read: no pulse
        run("R7", 1'b1, 8'h05, 32'h0, 16);
        run("R3", 1'b0, 8'h06, 32'h0, 8);
        run("R11", 1'b0, 8'h02, {16'hE600, 16'h0}, 24);
        // R11: reset mid-operation clears register and latch
        settle = 1'b1;
        rst_n  = 1'b0;
        wait_clk(3);
        rst_n    = 1'b1;
        exp_ctrl = 16'h0000;
        exp_wel  = 1'b0;
        wait_clk(4);
        check("R11", 32'(ctrl_bits), 32'd0, "ctrl after second reset");
        settle = 1'b0;
        run("R11", 1'b0, 8'h02, {16'h8000, 16'h0}, 24);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule